// File: doc/BRIEF.md
# Indexed ADC Host Register Interface

This block sits between a host bus of four byte-wide ports and a 12-bit successive-approximation converter core that has a simple start/busy/data handshake. Port 0 holds an index. Port 1 acts on whatever that index selects: the input-channel register, a software start strobe, the busy flag, the overrun flag, or the timer-interrupt clear. Ports 2 and 3 return the last result in two parts.

A conversion can be started by one of three sources, picked by a static 2-bit select input. The first is a host write, the second is an external active-low pulse that is synchronised on chip, and the third is the active-low output of a periodic timer. Each falling edge on the chosen source starts exactly one conversion, however long the level stays low. A start that arrives while a conversion is still running is dropped and recorded in a sticky overrun flag.

A conversion-complete interrupt and a timer interrupt share one request line, and each has its own clear. The result registers take the new 12-bit value in one cycle, when the core drops busy, so the two byte reads always belong to the same conversion. `host_rdata` is combinational from the address and the state; read side effects take place on the clock edge where `host_rd` is high.

Top module: `adc_hostif`

## Requirements
- R1: After reset `adc_start`, `irq` and `adc_chan` are 0, the port 0 index is 0x00, and reading port 1, port 2 or port 3 returns 0x00.
- R2: A write to port 0 stores the full byte as the index, and reading port 0 returns it. A port 1 write while the index is 0x01 loads `host_wdata[3:0]` into the channel register, which drives `adc_chan`. A port 1 write under any other index leaves the channel register unchanged.
- R3: With `trig_sel` = 2'b00, a port 1 write while the index is 0x00 gives one single-cycle `adc_start` pulse. With any other `trig_sel` value, that write starts nothing.
- R4: With `trig_sel` = 2'b01, each falling edge of `ext_trig_n` (after a two-flop synchroniser) gives exactly one `adc_start`, also when the low level lasts longer than a whole conversion. In other modes `ext_trig_n` starts nothing.
- R5: With `trig_sel` = 2'b10, each falling edge of `tmr_out_n` gives exactly one `adc_start`. With `trig_sel` = 2'b11, no source starts a conversion.
- R6: A port 1 read under any index other than 0x02 returns the busy flag in bit 0 (1 = busy) and zeros in bits 7:1. The flag is 1 from the start pulse until the cycle after the core drops `adc_busy`.
- R7: Port 2 returns result bits 3:0 in bits 3:0 and zeros in bits 7:4. Port 3 returns result bits 11:4. The result registers take `adc_data` only on the edge after `adc_busy` falls, and they keep the old value while a new conversion runs.
- R8: A start request from the selected source while busy is 1 gives no `adc_start` and sets the overrun flag. A port 1 read while the index is 0x02 returns the flag in bit 0 and clears it.
- R9: The conversion-complete interrupt becomes pending when a conversion finishes. A port 3 read clears it. Port 2 reads do not clear it.
- R10: A rising edge of `tmr_irq_evt` makes the timer interrupt pending. A port 1 write while the index is 0x08 clears it. Port 1 writes under any other index do not clear it.
- R11: `irq` is 1 exactly while at least one of the two interrupts is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_addr | input | 2 | Port number 0..3 |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational |
| trig_sel | input | 2 | Trigger source: 00 software, 01 external, 10 timer, 11 none |
| ext_trig_n | input | 1 | External asynchronous active-low trigger |
| tmr_out_n | input | 1 | Synchronous active-low timer output |
| tmr_irq_evt | input | 1 | Synchronous timer interrupt event, rising-edge sensitive |
| adc_start | output | 1 | Single-cycle conversion start to the core |
| adc_chan | output | 4 | Selected input channel |
| adc_busy | input | 1 | Core busy; its falling edge marks a result as valid |
| adc_data | input | 12 | Core result, valid when busy falls |
| irq | output | 1 | Combined interrupt request |

## Verification
The start path is exercised with four trigger patterns. A software write with the matching select must start a conversion, and the same write under a different select must not. An external low level held longer than a whole conversion shows that the block reacts to the edge and not the level. A short external pulse shows that the synchroniser still catches it. Timer edges under the wrong select and under the "none" select show that the source multiplexer blocks them. Back-to-back starts show that a busy conversion drops the second request and flags an overrun. Two conversions with different data, with a high-byte read in the middle of the second, show that the result holds its old value until it changes in one step.

// File: rtl/hostif_pkg.sv
package hostif_pkg;

  typedef enum logic [1:0] {
    TRIG_SW  = 2'd0,
    TRIG_EXT = 2'd1,
    TRIG_TMR = 2'd2,
    TRIG_OFF = 2'd3
  } trig_sel_e;

  localparam logic [1:0] PORT_INDEX  = 2'd0;
  localparam logic [1:0] PORT_ACCESS = 2'd1;
  localparam logic [1:0] PORT_RES_LO = 2'd2;
  localparam logic [1:0] PORT_RES_HI = 2'd3;

  localparam logic [7:0] IDX_START = 8'h00;
  localparam logic [7:0] IDX_CHAN  = 8'h01;
  localparam logic [7:0] IDX_OVR   = 8'h02;
  localparam logic [7:0] IDX_TCLR  = 8'h08;

endpackage

// File: rtl/hostif_fall_det.sv
module hostif_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_n,
  output logic fall
);

  logic lvl;
  logic prev_q;

  generate
    if (STAGES == 0) begin : g_direct
      assign lvl = in_n;
    end else begin : g_sync
      logic [STAGES-1:0] sync_q, sync_d;
      always_comb begin
        sync_d[0] = in_n;
        for (int i = 1; i < STAGES; i++) sync_d[i] = sync_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
      end
      assign lvl = sync_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl;
  end

  assign fall = prev_q & ~lvl;

  // R4: a held low level yields a single-cycle edge indication
  a_r4_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

endmodule

// File: rtl/hostif_conv_ctl.sv
module hostif_conv_ctl #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              ovr_clr,
  input  logic              adc_busy,
  input  logic [DATA_W-1:0] adc_data,
  output logic              adc_start,
  output logic              conv_busy,
  output logic              done,
  output logic              ovr_flag,
  output logic [DATA_W-1:0] result
);

  logic              start_q, start_d;
  logic              busy_q, busy_d;
  logic              core_busy_q;
  logic              ovr_q, ovr_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic              start_ok;

  assign done     = core_busy_q & ~adc_busy & busy_q;
  assign start_ok = start_req & ~busy_q;

  always_comb begin
    start_d = start_ok;
    busy_d  = busy_q;
    if (start_ok)  busy_d = 1'b1;
    else if (done) busy_d = 1'b0;
    ovr_d = ovr_q;
    if (ovr_clr)            ovr_d = 1'b0;
    if (start_req & busy_q) ovr_d = 1'b1;
    res_d = done ? adc_data : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q     <= 1'b0;
      busy_q      <= 1'b0;
      core_busy_q <= 1'b0;
      ovr_q       <= 1'b0;
      res_q       <= '0;
    end else begin
      start_q     <= start_d;
      busy_q      <= busy_d;
      core_busy_q <= adc_busy;
      ovr_q       <= ovr_d;
      res_q       <= res_d;
    end
  end

  assign adc_start = start_q;
  assign conv_busy = busy_q;
  assign ovr_flag  = ovr_q;
  assign result    = res_q;

  // R8: no start pulse may leave while a conversion is outstanding
  a_r8_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !start_q);
  // R7: result registers hold while the core reports busy
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    adc_busy |=> $stable(res_q));
  // R6: busy flag stays up while the core is still converting
  a_r6_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && adc_busy) |=> busy_q);

endmodule

// File: rtl/hostif_irq_ctrl.sv
module hostif_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic adc_clr,
  input  logic tmr_evt,
  input  logic tmr_clr,
  output logic irq
);

  logic adc_pend_q, adc_pend_d;
  logic tmr_pend_q, tmr_pend_d;
  logic tmr_evt_q;
  logic tmr_rise;

  assign tmr_rise = tmr_evt & ~tmr_evt_q;

  always_comb begin
    adc_pend_d = adc_pend_q;
    if (adc_clr) adc_pend_d = 1'b0;
    if (done)    adc_pend_d = 1'b1;
    tmr_pend_d = tmr_pend_q;
    if (tmr_clr)  tmr_pend_d = 1'b0;
    if (tmr_rise) tmr_pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_pend_q <= 1'b0;
      tmr_pend_q <= 1'b0;
      tmr_evt_q  <= 1'b0;
    end else begin
      adc_pend_q <= adc_pend_d;
      tmr_pend_q <= tmr_pend_d;
      tmr_evt_q  <= tmr_evt;
    end
  end

  assign irq = adc_pend_q | tmr_pend_q;

  // R9: reading the high byte clears the conversion interrupt
  a_r9_adc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_clr && !done) |=> !adc_pend_q);
  // R10: the index-8 write clears the timer interrupt
  a_r10_tmr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_clr && !tmr_rise) |=> !tmr_pend_q);
  // R11: with both sources quiet the request line drops after a clear of both
  a_r11_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_clr && !done && tmr_clr && !tmr_rise) |=> !irq);

endmodule

// File: rtl/adc_hostif.sv
module adc_hostif
  import hostif_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CHAN_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic [1:0]        trig_sel,
  input  logic              ext_trig_n,
  input  logic              tmr_out_n,
  input  logic              tmr_irq_evt,
  output logic              adc_start,
  output logic [CHAN_W-1:0] adc_chan,
  input  logic              adc_busy,
  input  logic [DATA_W-1:0] adc_data,
  output logic              irq
);

  localparam int LO_W = DATA_W - 8;

  logic [7:0]        index_q, index_d;
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic              acc_wr, acc_rd;
  logic              sw_req, ext_fall, tmr_fall, start_req;
  logic              ovr_clr, adc_clr, tmr_clr;
  logic              conv_busy, done, ovr_flag;
  logic [DATA_W-1:0] result;
  trig_sel_e         src;

  assign src    = trig_sel_e'(trig_sel);
  assign acc_wr = host_wr && (host_addr == PORT_ACCESS);
  assign acc_rd = host_rd && (host_addr == PORT_ACCESS);

  assign sw_req  = acc_wr && (index_q == IDX_START);
  assign tmr_clr = acc_wr && (index_q == IDX_TCLR);
  assign ovr_clr = acc_rd && (index_q == IDX_OVR);
  assign adc_clr = host_rd && (host_addr == PORT_RES_HI);

  always_comb begin
    index_d = index_q;
    if (host_wr && (host_addr == PORT_INDEX)) index_d = host_wdata;
    chan_d = chan_q;
    if (acc_wr && (index_q == IDX_CHAN)) chan_d = host_wdata[CHAN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= '0;
      chan_q  <= '0;
    end else begin
      index_q <= index_d;
      chan_q  <= chan_d;
    end
  end

  hostif_fall_det #(.STAGES(SYNC_STAGES)) u_ext_det (
    .clk(clk), .rst_n(rst_n), .in_n(ext_trig_n), .fall(ext_fall));

  hostif_fall_det #(.STAGES(0)) u_tmr_det (
    .clk(clk), .rst_n(rst_n), .in_n(tmr_out_n), .fall(tmr_fall));

  always_comb begin
    unique case (src)
      TRIG_SW:  start_req = sw_req;
      TRIG_EXT: start_req = ext_fall;
      TRIG_TMR: start_req = tmr_fall;
      default:  start_req = 1'b0;
    endcase
  end

  hostif_conv_ctl #(.DATA_W(DATA_W)) u_conv (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .ovr_clr(ovr_clr),
    .adc_busy(adc_busy), .adc_data(adc_data), .adc_start(adc_start),
    .conv_busy(conv_busy), .done(done), .ovr_flag(ovr_flag), .result(result));

  hostif_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .done(done), .adc_clr(adc_clr),
    .tmr_evt(tmr_irq_evt), .tmr_clr(tmr_clr), .irq(irq));

  always_comb begin
    host_rdata = '0;
    unique case (host_addr)
      PORT_INDEX:  host_rdata = index_q;
      PORT_ACCESS: host_rdata[0] = (index_q == IDX_OVR) ? ovr_flag : conv_busy;
      PORT_RES_LO: host_rdata[LO_W-1:0] = result[LO_W-1:0];
      default:     host_rdata = result[DATA_W-1:LO_W];
    endcase
  end

  assign adc_chan = chan_q;

  // R3: in any non-software mode a host start write never produces a start
  a_r3_sw_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (src != TRIG_SW && !ext_fall && !tmr_fall) |=> !adc_start);
  // R5: with no source selected nothing starts
  a_r5_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (src == TRIG_OFF) |=> !adc_start);
  // R2: the channel register only moves on an index-1 access write
  a_r2_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_wr && index_q == IDX_CHAN) |=> $stable(adc_chan));

endmodule

// File: tb/adc_hostif_tb_top.sv
`timescale 1ns/1ps
module adc_hostif_tb_top;

  localparam int CONV = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [1:0]  trig_sel = 2'b11;
  logic        ext_trig_n = 1'b1, tmr_out_n = 1'b1, tmr_irq_evt = 1'b0;
  logic        adc_start;
  logic [3:0]  adc_chan;
  logic        adc_busy = 1'b0;
  logic [11:0] adc_data = '0;
  logic        irq;

  logic [11:0] next_data = '0;
  int          cnt = 0;
  int          starts = 0;
  int          checks = 0, failures = 0;
  bit          finished = 0;

  always #2 clk = ~clk;

  adc_hostif dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .trig_sel(trig_sel), .ext_trig_n(ext_trig_n), .tmr_out_n(tmr_out_n),
    .tmr_irq_evt(tmr_irq_evt), .adc_start(adc_start), .adc_chan(adc_chan),
    .adc_busy(adc_busy), .adc_data(adc_data), .irq(irq));

  // Behavioural converter core
  always @(negedge clk) begin
    if (adc_start) begin
      starts   <= starts + 1;
      adc_busy <= 1'b1;
      cnt      <= CONV;
    end else if (adc_busy) begin
      if (cnt == 1) begin
        adc_busy <= 1'b0;
        adc_data <= next_data;
      end
      cnt <= cnt - 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1", "adc_start", adc_start, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "adc_chan", adc_chan, 0);
    host_read(2'd0, d); chk("R1", "index", d, 8'h00);
    host_read(2'd1, d); chk("R1", "port1", d, 8'h00);
    host_read(2'd2, d); chk("R1", "port2", d, 8'h00);
    host_read(2'd3, d); chk("R1", "port3", d, 8'h00);
  endtask

  task automatic t_channel();
    logic [7:0] d;
    int s0;
    host_write(2'd0, 8'h01);
    host_read(2'd0, d); chk("R2", "index readback", d, 8'h01);
    host_write(2'd1, 8'h2B);
    wait_cyc(1); chk("R2", "channel load", adc_chan, 4'hB);
    s0 = starts;
    host_write(2'd0, 8'h00);
    host_write(2'd1, 8'h05);
    wait_cyc(3);
    chk("R2", "channel kept at index 0", adc_chan, 4'hB);
    chk("R5", "no start with select 11", starts - s0, 0);
  endtask

  task automatic t_software();
    logic [7:0] d;
    int s0;
    trig_sel = 2'b01;
    s0 = starts;
    host_write(2'd0, 8'h00);
    host_write(2'd1, 8'h00);
    wait_cyc(3);
    chk("R3", "sw write ignored in ext mode", starts - s0, 0);
    trig_sel = 2'b00;
    next_data = 12'hA5C;
    s0 = starts;
    host_write(2'd1, 8'h00);
    host_read(2'd1, d); chk("R6", "busy during conversion", d, 8'h01);
    wait_cyc(15);
    chk("R3", "one sw start", starts - s0, 1);
    host_read(2'd1, d); chk("R6", "busy cleared", d, 8'h00);
    chk("R9", "irq after completion", irq, 1);
    host_read(2'd2, d); chk("R7", "low nibble", d, 8'h0C);
    wait_cyc(1); chk("R9", "port2 read keeps irq", irq, 1);
  endtask

  task automatic t_result_hold();
    logic [7:0] d;
    next_data = 12'h3F1;
    host_write(2'd1, 8'h00);
    wait_cyc(1);
    host_read(2'd3, d); chk("R7", "old high byte during busy", d, 8'hA5);
    wait_cyc(15);
    host_read(2'd2, d); chk("R7", "new low nibble", d, 8'h01);
    host_read(2'd3, d); chk("R7", "new high byte", d, 8'h3F);
    wait_cyc(1); chk("R9", "port3 read clears irq", irq, 0);
  endtask

  task automatic t_external();
    logic [7:0] d;
    int s0;
    trig_sel = 2'b01;
    next_data = 12'h123;
    s0 = starts;
    @(negedge clk); ext_trig_n = 1'b0;
    wait_cyc(25);
    chk("R4", "long low gives one start", starts - s0, 1);
    ext_trig_n = 1'b1;
    wait_cyc(4);
    s0 = starts;
    @(negedge clk); ext_trig_n = 1'b0;
    repeat (2) @(negedge clk);
    ext_trig_n = 1'b1;
    wait_cyc(15);
    chk("R4", "short pulse gives one start", starts - s0, 1);
    host_read(2'd3, d);
    trig_sel = 2'b10;
    s0 = starts;
    @(negedge clk); ext_trig_n = 1'b0;
    wait_cyc(6); ext_trig_n = 1'b1;
    wait_cyc(4);
    chk("R4", "ext ignored in timer mode", starts - s0, 0);
  endtask

  task automatic t_timer();
    logic [7:0] d;
    int s0;
    trig_sel = 2'b10;
    s0 = starts;
    @(negedge clk); tmr_out_n = 1'b0;
    @(negedge clk); tmr_out_n = 1'b1;
    wait_cyc(15);
    chk("R5", "timer edge gives one start", starts - s0, 1);
    host_read(2'd3, d);
    trig_sel = 2'b11;
    s0 = starts;
    @(negedge clk); tmr_out_n = 1'b0;
    @(negedge clk); tmr_out_n = 1'b1;
    wait_cyc(6);
    chk("R5", "timer ignored with select 11", starts - s0, 0);
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    int s0;
    trig_sel = 2'b00;
    host_write(2'd0, 8'h00);
    s0 = starts;
    host_write(2'd1, 8'h00);
    host_write(2'd1, 8'h00);
    wait_cyc(15);
    chk("R8", "second start dropped", starts - s0, 1);
    host_write(2'd0, 8'h02);
    host_read(2'd1, d); chk("R8", "overrun flag set", d, 8'h01);
    host_read(2'd1, d); chk("R8", "overrun cleared by read", d, 8'h00);
    host_read(2'd3, d);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    @(negedge clk); tmr_irq_evt = 1'b1;
    @(negedge clk); tmr_irq_evt = 1'b0;
    wait_cyc(1); chk("R10", "timer irq pending", irq, 1);
    host_write(2'd0, 8'h01);
    host_write(2'd1, 8'h03);
    wait_cyc(1); chk("R10", "index 1 write keeps timer irq", irq, 1);
    trig_sel = 2'b00;
    host_write(2'd0, 8'h00);
    host_write(2'd1, 8'h00);
    wait_cyc(15);
    host_read(2'd3, d);
    wait_cyc(1); chk("R11", "timer irq still on line", irq, 1);
    host_write(2'd0, 8'h08);
    host_write(2'd1, 8'h00);
    wait_cyc(1); chk("R10", "index 8 write clears", irq, 0);
    chk("R11", "line low with nothing pending", irq, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_channel();
    t_software();
    t_result_hold();
    t_external();
    t_timer();
    t_overrun();
    t_irq();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule